// File: doc/BRIEF.md
# Watermark-Triggered DMA Transmit Buffer

This block is a first-in first-out byte buffer placed between a DMA controller and a serial transmit shifter. The DMA side writes bytes through a push port. The serial side takes the oldest byte through a pop port. The head byte is always visible on `pop_data_o`, so the consumer reads it in the same cycle that it pops.

A programmable watermark controls when the DMA is asked for more data. When an evaluation finds the fill level at or below the watermark, the block raises a burst request. The request stays high until the DMA reports that the burst is complete. A burst that fits into the space above the watermark can never overflow the buffer. A higher watermark lowers the chance of running dry, but it costs more bursts per block.

Pushing into a full buffer and popping from an empty one are both recorded in sticky error flags. Software clears these flags with a single pulse. The fill level and the empty and full flags are available as outputs.

Top module: `wm_tx_fifo`

## Requirements
- R1: `level_o` reports the number of stored entries, from 0 to DEPTH. A push and a pop in the same cycle leave the level unchanged when the buffer is neither empty nor full.
- R2: `empty_o` is high exactly when the level is 0, and `full_o` is high exactly when the level equals DEPTH.
- R3: Bytes leave in the order they were accepted. While the buffer is not empty, `pop_data_o` shows the oldest stored byte, and that byte changes only when a pop occurs.
- R4: Each clock edge at which `dma_req_o` is low evaluates the request. If the level before that edge is less than or equal to the watermark, `dma_req_o` is high after the edge.
- R5: Once high, `dma_req_o` stays high until an edge at which `burst_done_i` is high. After that edge it is low for at least one cycle, and then it is evaluated again as in R4. A `burst_done_i` pulse while the request is low has no effect.
- R6: A push while the buffer is full is dropped, even if a pop occurs in the same cycle. The dropped push leaves the stored bytes unchanged and sets the sticky flag `ovf_o`.
- R7: A pop while the buffer is empty changes no state except that it sets the sticky flag `udf_o`. A push in the same cycle is still stored, giving a level of 1.
- R8: `err_clr_i` clears both flags at the next edge. A new error event in the same cycle keeps its flag set.
- R9: `wmark_we_i` loads `wmark_wdata_i` (0 to DEPTH-1) into the watermark register. The new value is used from the following evaluation on, and the write leaves the stored data and the level untouched.
- R10: While `rst_ni` is low, the buffer is empty, both flags are low, `dma_req_o` is low and the watermark is 0.
- R11: With DEPTH 64, a watermark of 48 and bursts of DEPTH minus watermark (16 bytes) served on each request, a 240-byte block is delivered in exactly 15 requests without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wmark_we_i | input | 1 | Watermark register write strobe |
| wmark_wdata_i | input | $clog2(DEPTH) | New watermark value |
| push_i | input | 1 | DMA write of one byte |
| push_data_i | input | DW | Byte written by the DMA |
| pop_i | input | 1 | Serial side consumes the head byte |
| pop_data_o | output | DW | Oldest stored byte (valid while not empty) |
| burst_done_i | input | 1 | DMA signals that the current burst is complete |
| dma_req_o | output | 1 | Destination burst request to the DMA |
| err_clr_i | input | 1 | Clears both sticky error flags |
| level_o | output | $clog2(DEPTH+1) | Fill level |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| ovf_o | output | 1 | Sticky transmit overflow flag |
| udf_o | output | 1 | Sticky transmit underflow flag |

## Verification
The bench builds the block with its defaults, DEPTH 64 and 8-bit data. These values make the 48-entry watermark with 16-byte bursts and the 240-byte block directly reproducible. Because DEPTH is a power of two, pointers wrap naturally in this build. Filling all 64 entries takes only a few dozen cycles, so the full-buffer cases and their overflow corners are reached quickly. Watermark values of 0, 48 and 63 cover the lowest setting, the mid-range burst case and the highest setting of the request comparison.

// File: rtl/wm_tx_fifo_pkg.sv
package wm_tx_fifo_pkg;
  typedef enum logic {
    REQ_IDLE = 1'b0,
    REQ_WAIT = 1'b1
  } req_state_e;
endpackage

// File: rtl/wm_tx_fifo_store.sv
module wm_tx_fifo_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);
  localparam bit            POW2   = (DEPTH == (1 << AW));

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
  logic [LW-1:0] cnt_q;

  generate
    if (POW2) begin : g_wrap_nat
      assign wr_ptr_nx = wr_ptr_q + AW'(1);
      assign rd_ptr_nx = rd_ptr_q + AW'(1);
    end else begin : g_wrap_cmp
      assign wr_ptr_nx = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + AW'(1);
      assign rd_ptr_nx = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_nx;
      if (rd_en_i) rd_ptr_q <= rd_ptr_nx;
      unique case ({wr_en_i, rd_en_i})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q];
  assign level_o   = cnt_q;
  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == FULL_L);
endmodule

// File: rtl/wm_tx_fifo_req.sv
module wm_tx_fifo_req
  import wm_tx_fifo_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned LW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] level_i,
  input  logic [AW-1:0] wmark_i,
  input  logic          done_i,
  output logic          req_o
);
  req_state_e state_q, state_d;
  logic       at_mark;

  assign at_mark = (level_i <= LW'(wmark_i));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      REQ_IDLE: if (at_mark) state_d = REQ_WAIT;
      REQ_WAIT: if (done_i)  state_d = REQ_IDLE;
      default:               state_d = REQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= REQ_IDLE;
    else         state_q <= state_d;
  end

  assign req_o = (state_q == REQ_WAIT);
endmodule

// File: rtl/wm_tx_fifo_err.sv
module wm_tx_fifo_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_evt_i,
  input  logic udf_evt_i,
  input  logic clr_i,
  output logic ovf_o,
  output logic udf_o
);
  logic ovf_q, udf_q;

  // a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_evt_i | (ovf_q & ~clr_i);
      udf_q <= udf_evt_i | (udf_q & ~clr_i);
    end
  end

  assign ovf_o = ovf_q;
  assign udf_o = udf_q;
endmodule

// File: rtl/wm_tx_fifo.sv
module wm_tx_fifo
  import wm_tx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wmark_we_i,
  input  logic [AW-1:0] wmark_wdata_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  input  logic          burst_done_i,
  output logic          dma_req_o,
  input  logic          err_clr_i,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          udf_o
);
  logic [AW-1:0] wm_q;
  logic          wr_ok, rd_ok;
  logic          st_empty, st_full;
  logic [LW-1:0] st_level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wm_q <= '0;
    else if (wmark_we_i) wm_q <= wmark_wdata_i;
  end

  // full blocks a push even when a pop shares the cycle
  assign wr_ok = push_i & ~st_full;
  assign rd_ok = pop_i & ~st_empty;

  wm_tx_fifo_store #(
    .DEPTH (DEPTH),
    .DW    (DW),
    .AW    (AW),
    .LW    (LW)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_ok),
    .wr_data_i (push_data_i),
    .rd_en_i   (rd_ok),
    .rd_data_o (pop_data_o),
    .level_o   (st_level),
    .empty_o   (st_empty),
    .full_o    (st_full)
  );

  wm_tx_fifo_req #(
    .AW (AW),
    .LW (LW)
  ) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (st_level),
    .wmark_i (wm_q),
    .done_i  (burst_done_i),
    .req_o   (dma_req_o)
  );

  wm_tx_fifo_err u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovf_evt_i (push_i & st_full),
    .udf_evt_i (pop_i & st_empty),
    .clr_i     (err_clr_i),
    .ovf_o     (ovf_o),
    .udf_o     (udf_o)
  );

  assign level_o = st_level;
  assign empty_o = st_empty;
  assign full_o  = st_full;
endmodule

// File: rtl/wm_tx_fifo_chk.sv
module wm_tx_fifo_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 6,
  parameter int unsigned LW    = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic          burst_done_i,
  input logic          err_clr_i,
  input logic          dma_req_o,
  input logic [LW-1:0] level_o,
  input logic [AW-1:0] wm_q,
  input logic          empty_o,
  input logic          full_o,
  input logic          ovf_o,
  input logic          udf_o,
  input logic [DW-1:0] pop_data_o
);
  a_r1_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(level_o) <= DEPTH);

  a_r2_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));

  a_r3_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !pop_i) |=> (pop_data_o == $past(pop_data_o)));

  a_r4_req_at_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> ($past(level_o) <= LW'($past(wm_q))));

  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && !burst_done_i) |=> dma_req_o);

  a_r5_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && burst_done_i) |=> !dma_req_o);

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i) |=> (ovf_o && !empty_o));

  a_r6_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !err_clr_i) |=> ovf_o);

  a_r7_udf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i) |=> udf_o);

  a_r7_udf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udf_o && !err_clr_i) |=> udf_o);
endmodule

bind wm_tx_fifo wm_tx_fifo_chk #(
  .DEPTH (DEPTH),
  .DW    (DW),
  .AW    (AW),
  .LW    (LW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .burst_done_i (burst_done_i),
  .err_clr_i    (err_clr_i),
  .dma_req_o    (dma_req_o),
  .level_o      (level_o),
  .wm_q         (wm_q),
  .empty_o      (empty_o),
  .full_o       (full_o),
  .ovf_o        (ovf_o),
  .udf_o        (udf_o),
  .pop_data_o   (pop_data_o)
);

// File: tb/wm_tx_fifo_tb_top.sv
module wm_tx_fifo_tb_top;
  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wm_we = 1'b0;
  logic [AW-1:0] wm_wd = '0;
  logic          push = 1'b0;
  logic [DW-1:0] pdata = '0;
  logic          pop = 1'b0;
  logic [DW-1:0] qdata;
  logic          done = 1'b0;
  logic          req;
  logic          clr = 1'b0;
  logic [LW-1:0] level;
  logic          empty, full, ovf, udf;

  always #2.5 clk = ~clk;

  wm_tx_fifo #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wmark_we_i(wm_we), .wmark_wdata_i(wm_wd),
    .push_i(push), .push_data_i(pdata), .pop_i(pop), .pop_data_o(qdata),
    .burst_done_i(done), .dma_req_o(req), .err_clr_i(clr), .level_o(level),
    .empty_o(empty), .full_o(full), .ovf_o(ovf), .udf_o(udf)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // behavioural reference model
  int m_q[$];
  int m_wm = 0;
  bit m_req = 0, m_ovf = 0, m_udf = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete();
      m_wm = 0; m_req = 0; m_ovf = 0; m_udf = 0;
    end else begin
      int  n;
      bit  is_full, is_empty;
      n = m_q.size();
      is_full  = (n == DEPTH);
      is_empty = (n == 0);
      if (m_req) begin
        if (done) m_req = 0;
      end else if (n <= m_wm) begin
        m_req = 1;
      end
      m_ovf = (push && is_full) || (m_ovf && !clr);
      m_udf = (pop && is_empty) || (m_udf && !clr);
      if (pop && !is_empty) void'(m_q.pop_front());
      if (push && !is_full) m_q.push_back(int'(pdata));
      if (wm_we) m_wm = int'(wm_wd);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R1 level", int'(level), m_q.size());
    chk("R2 empty", int'(empty), int'(m_q.size() == 0));
    chk("R2 full", int'(full), int'(m_q.size() == DEPTH));
    if (m_q.size() > 0) chk("R3 head", int'(qdata), m_q[0]);
    chk("R4 R5 req", int'(req), int'(m_req));
    chk("R6 ovf", int'(ovf), int'(m_ovf));
    chk("R7 udf", int'(udf), int'(m_udf));
  endtask

  // drive at negedge, advance one clock, compare at the next negedge
  task automatic cyc(bit pu, int d, bit po, bit dn = 0, bit we = 0, int wd = 0, bit cl = 0);
    push = pu; pdata = DW'(d); pop = po; done = dn; wm_we = we; wm_wd = AW'(wd); clr = cl;
    @(posedge clk);
    @(negedge clk);
    push = 0; pop = 0; done = 0; wm_we = 0; clr = 0;
    cmp_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int reqs, total, left;
    bit in_burst;
    @(negedge clk);
    // R10 reset state
    chk("R10 level", int'(level), 0);
    chk("R10 empty", int'(empty), 1);
    chk("R10 req", int'(req), 0);
    chk("R10 flags", int'(ovf | udf), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_all();

    // R4: level 0 <= watermark 0 raises request
    cyc(0, 0, 0);
    chk("R4 req after eval", int'(req), 1);
    // R5: done drops it, re-raised one cycle later
    cyc(0, 0, 0, 1);
    chk("R5 req low after done", int'(req), 0);
    cyc(0, 0, 0);
    chk("R5 req reevaluated", int'(req), 1);
    cyc(0, 0, 0, 1);

    // R7: pop when empty with simultaneous push
    cyc(1, 8'hA5, 1);
    chk("R7 udf set", int'(udf), 1);
    chk("R7 push kept", int'(level), 1);
    chk("R3 head", int'(qdata), 8'hA5);
    // R8: clear
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R8 udf cleared", int'(udf), 0);

    // R3 fill to full with a pattern, R2 full
    for (int i = 1; i < DEPTH; i++) cyc(1, (i * 37 + 3) & 8'hFF, 0, req);
    chk("R2 full", int'(full), 1);
    // R6: push + pop while full, push dropped
    cyc(1, 8'h11, 1);
    chk("R6 ovf set", int'(ovf), 1);
    chk("R6 level after dropped push", int'(level), DEPTH - 1);
    // R1: push and pop mid-level keeps level
    cyc(1, 8'h22, 1);
    chk("R1 simultaneous", int'(level), DEPTH - 1);
    // R8: clear with a new event in the same cycle keeps flag
    cyc(1, 8'h33, 0);
    cyc(1, 8'h44, 0, 0, 0, 0, 1);
    chk("R8 event beats clear", int'(ovf), 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R8 ovf cleared", int'(ovf), 0);

    // R9: watermark 63 write, no flush, request on next evaluation
    cyc(0, 0, 1, req);
    chk("R9 before write", int'(req), 0);
    cyc(0, 0, 0, 0, 1, 63);
    chk("R9 no flush", int'(level), DEPTH - 1);
    cyc(0, 0, 0);
    chk("R9 new mark used", int'(req), 1);

    // drain, then set watermark 48
    while (int'(level) > 0) cyc(0, 0, 1, req);
    cyc(0, 0, 0, req, 1, 48);
    cyc(0, 0, 0, req);
    chk("R3 drained", int'(empty), 1);

    // R11: 240-byte block, 16-byte bursts
    reqs = 0; total = 0; left = 0; in_burst = 0;
    for (int c = 0; c < 4000 && (total < 240 || in_burst); c++) begin
      bit pu, dn, po;
      pu = 0; dn = 0;
      if (!in_burst && req && total < 240) begin
        in_burst = 1; left = DEPTH - 48; reqs++;
      end
      if (in_burst && left > 0) begin
        pu = 1; left--; total++;
      end else if (in_burst) begin
        dn = 1; in_burst = 0;
      end
      po = (c % 3 == 0) && (m_q.size() > 0);
      cyc(pu, total & 8'hFF, po, dn);
    end
    chk("R11 request count", reqs, 15);
    chk("R11 bytes pushed", total, 240);
    chk("R11 no overflow", int'(ovf), 0);
    while (int'(level) > 0) cyc(0, 0, 1, req);
    chk("R11 no underflow", int'(udf), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule